// File: doc/BRIEF.md
# Power-Up Soft-Start and Fault Supervisor

This block is the digital supervisor of a two-output step-down regulator. It takes comparator flags from the analog side and decides when the power stage may switch. The flags are: supply above the power-on level, supply above the lockout level, supply collapsed, the per-output regulation window and per-output overvoltage. It also reads the shutdown and standby requests.

From these it drives four outputs. A switching enable gates the power stage. A 3-bit code sets the current-limit ceiling. A force signal holds the low-side switch on. A pull-low request drives the open-drain power-good pin.

When the supply is good and nothing holds the part off, the current-limit ceiling climbs in five equal steps, each `RAMP_STEP_CYC` clock cycles long. Power-good may release only after the climb ends. An overvoltage on either output latches a shutdown that keeps the low-side switch on and discharges the output. Only a shutdown request or a collapse of the supply clears that latch.

Top module: `pwr_supervisor`

## Requirements
- R1: While `rst` is high, or while `vcc_por_ok` is low or `vcc_collapsed` is high, the outputs are `sw_en`=0, `lowside_force`=1, `ilim_code`=0 and `pg_pull_low`=1. Leaving this state clears any overvoltage latch and restarts the ramp from code 1.
- R2: With the supply above the power-on level but `vcc_uvlo_ok` low, switching is inhibited and the low-side switch is forced on (`sw_en`=0, `lowside_force`=1, `ilim_code`=0, `pg_pull_low`=1).
- R3: Once enabled, `ilim_code` takes the values 1, 2, 3, 4, 5 in order, each held for `RAMP_STEP_CYC` cycles. Code k stands for k×20% of full current. `sw_en`=1 and `lowside_force`=0 throughout.
- R4: After 5×`RAMP_STEP_CYC` cycles of ramp, the block enters run mode with `ilim_code`=5 and stays there while its conditions hold.
- R5: Shutdown (`shutdown`=1) gives `sw_en`=0, `lowside_force`=1, `ilim_code`=0 and `pg_pull_low`=1. Standby (`standby`=1, shutdown low) gives the same, except that `lowside_force`=0. Leaving either one restarts the ramp at code 1.
- R6: `pg_pull_low` is 0 only in run mode with both bits of `out_win_ok` set. It returns to 1 one cycle after either bit drops and to 0 one cycle after both are set again, with no latching.
- R7: An `out_ovp` bit set on either output, with the supply above the power-on level and no shutdown, latches a fault. The fault gives `sw_en`=0, `lowside_force`=1, `ilim_code`=0 and `pg_pull_low`=1, and these persist after `out_ovp` clears.
- R8: The fault latch ignores standby and lockout. It clears only through a shutdown request, which also takes precedence over a concurrent overvoltage, or through R1. A later release starts a fresh ramp at code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_por_ok | input | 1 | Supply above the power-on level |
| vcc_uvlo_ok | input | 1 | Supply above the lockout level |
| vcc_collapsed | input | 1 | Supply below the collapse level (about 1 V) |
| shutdown | input | 1 | Shutdown request, active high |
| standby | input | 1 | Standby request, active high |
| out_win_ok | input | NUM_OUT | Per output: voltage inside the power-good window |
| out_ovp | input | NUM_OUT | Per output: overvoltage comparator tripped |
| sw_en | output | 1 | Power stage may switch |
| ilim_code | output | CODE_W | Current-limit ceiling, 0 = off, 1..5 = 20%..100% |
| lowside_force | output | 1 | Hold the low-side switch on |
| pg_pull_low | output | 1 | Pull the open-drain power-good pin low |

## Verification
A change on a supply, shutdown, standby or overvoltage input is registered into the mode at the next edge. It reaches the outputs one edge later, so the bench allows two edges before it samples. A window change goes straight into the power-good register and shows after one edge. The ramp is checked edge by edge against a count of edges since enable. Code k is due 2+(k−1)×`RAMP_STEP_CYC` edges after the enable, and power-good 2+5×`RAMP_STEP_CYC` edges after it. Every sample is taken at the falling edge, after the rising edge that settles the result.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_UVLO  = 3'd1,
    ST_SHDN  = 3'd2,
    ST_STBY  = 3'd3,
    ST_RAMP  = 3'd4,
    ST_RUN   = 3'd5,
    ST_FAULT = 3'd6
  } sup_state_e;
endpackage

// File: rtl/sup_ramp_timer.sv
module sup_ramp_timer #(
  parameter int STEP_CYC  = 34000,
  parameter int NUM_STEPS = 5,
  parameter int CODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ramp_act,
  output logic [CODE_W-1:0] step,
  output logic              ramp_end
);
  localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CNT_W-1:0]  CNT_MAX   = CNT_W'(STEP_CYC - 1);
  localparam logic [CODE_W-1:0] STEP_LAST = CODE_W'(NUM_STEPS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !ramp_act) begin
      cnt  <= '0;
      step <= CODE_W'(1);
    end else if (cnt == CNT_MAX) begin
      cnt <= '0;
      if (step != STEP_LAST) step <= step + CODE_W'(1);
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign ramp_end = ramp_act && (step == STEP_LAST) && (cnt == CNT_MAX);

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (step >= CODE_W'(1)) && (step <= STEP_LAST)); // R3
  AST_STEP_MONO: assert property (@(posedge clk) disable iff (rst)
    ramp_act |=> (!ramp_act || step >= $past(step))); // R3
endmodule

// File: rtl/sup_mode_ctrl.sv
module sup_mode_ctrl
  import sup_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vcc_por_ok,
  input  logic               vcc_uvlo_ok,
  input  logic               vcc_collapsed,
  input  logic               shutdown,
  input  logic               standby,
  input  logic [NUM_OUT-1:0] out_ovp,
  input  logic               ramp_end,
  output sup_state_e         state
);
  sup_state_e nxt;
  logic       supply_dead;

  assign supply_dead = vcc_collapsed || !vcc_por_ok;

  always_comb begin
    if (supply_dead)                             nxt = ST_OFF;
    else if (shutdown)                           nxt = ST_SHDN;
    else if (state == ST_FAULT || (|out_ovp))    nxt = ST_FAULT;
    else if (!vcc_uvlo_ok)                       nxt = ST_UVLO;
    else if (standby)                            nxt = ST_STBY;
    else if (state == ST_RUN || (state == ST_RAMP && ramp_end)) nxt = ST_RUN;
    else                                         nxt = ST_RAMP;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= nxt;
  end

  AST_DEAD_OFF: assert property (@(posedge clk) disable iff (rst)
    supply_dead |=> state == ST_OFF); // R1
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAULT && !supply_dead && !shutdown) |=> state == ST_FAULT); // R8
  AST_OVP_TRIP: assert property (@(posedge clk) disable iff (rst)
    ((|out_ovp) && !supply_dead && !shutdown) |=> state == ST_FAULT); // R7
endmodule

// File: rtl/sup_out_stage.sv
module sup_out_stage
  import sup_pkg::*;
#(
  parameter int NUM_OUT   = 2,
  parameter int NUM_STEPS = 5,
  parameter int CODE_W    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  sup_state_e         state,
  input  logic [CODE_W-1:0]  step,
  input  logic [NUM_OUT-1:0] out_win_ok,
  output logic               sw_en,
  output logic [CODE_W-1:0]  ilim_code,
  output logic               lowside_force,
  output logic               pg_pull_low
);
  localparam logic [CODE_W-1:0] STEP_LAST = CODE_W'(NUM_STEPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en         <= 1'b0;
      ilim_code     <= '0;
      lowside_force <= 1'b1;
      pg_pull_low   <= 1'b1;
    end else begin
      sw_en         <= (state == ST_RAMP) || (state == ST_RUN);
      lowside_force <= (state == ST_OFF) || (state == ST_UVLO) ||
                       (state == ST_SHDN) || (state == ST_FAULT);
      pg_pull_low   <= !((state == ST_RUN) && (&out_win_ok));
      case (state)
        ST_RAMP: ilim_code <= step;
        ST_RUN:  ilim_code <= STEP_LAST;
        default: ilim_code <= '0;
      endcase
    end
  end

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
    !(sw_en && lowside_force)); // R2
  AST_PG_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    !pg_pull_low |-> (sw_en && ilim_code == STEP_LAST)); // R6
  AST_OFF_NO_CODE: assert property (@(posedge clk) disable iff (rst)
    !sw_en |-> ilim_code == '0); // R5
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import sup_pkg::*;
#(
  parameter int RAMP_STEP_CYC = 34000,
  parameter int NUM_STEPS     = 5,
  parameter int CODE_W        = 3,
  parameter int NUM_OUT       = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vcc_por_ok,
  input  logic               vcc_uvlo_ok,
  input  logic               vcc_collapsed,
  input  logic               shutdown,
  input  logic               standby,
  input  logic [NUM_OUT-1:0] out_win_ok,
  input  logic [NUM_OUT-1:0] out_ovp,
  output logic               sw_en,
  output logic [CODE_W-1:0]  ilim_code,
  output logic               lowside_force,
  output logic               pg_pull_low
);
  sup_state_e        state;
  logic [CODE_W-1:0] step;
  logic              ramp_end;

  sup_mode_ctrl #(.NUM_OUT(NUM_OUT)) mode_i (
    .clk(clk), .rst(rst), .vcc_por_ok(vcc_por_ok), .vcc_uvlo_ok(vcc_uvlo_ok),
    .vcc_collapsed(vcc_collapsed), .shutdown(shutdown), .standby(standby),
    .out_ovp(out_ovp), .ramp_end(ramp_end), .state(state)
  );

  sup_ramp_timer #(.STEP_CYC(RAMP_STEP_CYC), .NUM_STEPS(NUM_STEPS), .CODE_W(CODE_W)) ramp_i (
    .clk(clk), .rst(rst), .ramp_act(state == ST_RAMP), .step(step), .ramp_end(ramp_end)
  );

  sup_out_stage #(.NUM_OUT(NUM_OUT), .NUM_STEPS(NUM_STEPS), .CODE_W(CODE_W)) out_i (
    .clk(clk), .rst(rst), .state(state), .step(step), .out_win_ok(out_win_ok),
    .sw_en(sw_en), .ilim_code(ilim_code), .lowside_force(lowside_force),
    .pg_pull_low(pg_pull_low)
  );
endmodule

// File: tb/pwr_supervisor_tb.sv
module pwr_supervisor_tb_top;
  localparam int S = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por = 1'b0, uvlo = 1'b0, dead = 1'b0, shdn = 1'b0, stby = 1'b0;
  logic [1:0] win = 2'b11, ovp = 2'b00;
  logic sw_en, lowside_force, pg_pull_low;
  logic [2:0] ilim_code;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_supervisor #(.RAMP_STEP_CYC(S)) dut_i (
    .clk(clk), .rst(rst), .vcc_por_ok(por), .vcc_uvlo_ok(uvlo), .vcc_collapsed(dead),
    .shutdown(shdn), .standby(stby), .out_win_ok(win), .out_ovp(ovp),
    .sw_en(sw_en), .ilim_code(ilim_code), .lowside_force(lowside_force),
    .pg_pull_low(pg_pull_low)
  );

  typedef struct packed {
    logic por, uvlo, dead, shdn, stby;
    logic [1:0] win, ovp;
    logic [5:0] hold;
    logic sw, frc;
    logic [2:0] il;
    logic pl;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mk(int p, int u, int d, int sd, int sb, int w, int o, int h,
                              int s, int f, int il, int pl, int rq);
    vec_t v;
    v.por = (p != 0); v.uvlo = (u != 0); v.dead = (d != 0);
    v.shdn = (sd != 0); v.stby = (sb != 0);
    v.win = 2'(w); v.ovp = 2'(o); v.hold = 6'(h);
    v.sw = (s != 0); v.frc = (f != 0); v.il = 3'(il); v.pl = (pl != 0);
    v.req = 4'(rq);
    return v;
  endfunction

  // por uvlo dead shdn stby win ovp hold | sw frc il pl | req
  localparam vec_t VECS [0:20] = '{
    mk(0,0,0,0,0,3,0, 3, 0,1,0,1, 1),  // R1 below power-on level
    mk(1,0,0,0,0,3,0, 3, 0,1,0,1, 2),  // R2 lockout
    mk(1,1,0,1,0,3,0, 3, 0,1,0,1, 5),  // R5 shutdown
    mk(1,1,0,0,1,3,0, 3, 0,0,0,1, 5),  // R5 standby
    mk(1,1,0,0,0,3,0, 2, 1,0,1,1, 3),  // R3 ramp starts at code 1
    mk(1,1,0,0,0,3,0,30, 1,0,5,0, 4),  // R4 run, power-good released
    mk(1,1,0,0,0,1,0, 2, 1,0,5,1, 6),  // R6 one window lost
    mk(1,1,0,0,0,3,0, 2, 1,0,5,0, 6),  // R6 no latch
    mk(1,1,0,0,0,3,2, 3, 0,1,0,1, 7),  // R7 overvoltage on output 1
    mk(1,1,0,0,0,3,0, 3, 0,1,0,1, 7),  // R7 persists after clear
    mk(1,1,0,0,1,3,0, 3, 0,1,0,1, 8),  // R8 standby ignored
    mk(1,0,0,0,0,3,0, 3, 0,1,0,1, 8),  // R8 lockout ignored
    mk(1,1,0,1,0,3,0, 3, 0,1,0,1, 8),  // R8 shutdown clears
    mk(1,1,0,0,0,3,0, 2, 1,0,1,1, 8),  // R8 fresh ramp
    mk(1,1,0,0,0,3,0,30, 1,0,5,0, 4),  // R4
    mk(1,1,0,0,0,3,1, 3, 0,1,0,1, 7),  // R7 overvoltage on output 0
    mk(1,1,1,0,0,3,0, 3, 0,1,0,1, 1),  // R1 supply collapse
    mk(1,1,0,0,0,3,0, 2, 1,0,1,1, 8),  // R8 collapse cleared latch
    mk(1,1,0,0,0,3,0,30, 1,0,5,0, 4),  // R4
    mk(1,1,0,1,0,3,3, 3, 0,1,0,1, 8),  // R8 shutdown over overvoltage
    mk(1,1,0,0,0,3,0, 2, 1,0,1,1, 8)   // R8 no latch taken
  };

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(int rq, logic s, logic f, logic [2:0] il, logic pl, string what);
    checks++;
    if (sw_en !== s || lowside_force !== f || ilim_code !== il || pg_pull_low !== pl) begin
      failures++;
      $display("FAIL R%0d %s: got sw=%b frc=%b il=%0d pl=%b exp sw=%b frc=%b il=%0d pl=%b",
               rq, what, sw_en, lowside_force, ilim_code, pg_pull_low, s, f, il, pl);
    end
  endtask

  initial begin
    tick(2);
    chk(1, 0, 1, 0, 1, "reset state"); // R1
    rst = 1'b0;

    for (int i = 0; i < 21; i++) begin
      por = VECS[i].por; uvlo = VECS[i].uvlo; dead = VECS[i].dead;
      shdn = VECS[i].shdn; stby = VECS[i].stby; win = VECS[i].win; ovp = VECS[i].ovp;
      tick(int'(VECS[i].hold));
      chk(int'(VECS[i].req), VECS[i].sw, VECS[i].frc, VECS[i].il, VECS[i].pl,
          $sformatf("vector %0d", i));
    end

    // R3 R4: edge-by-edge ramp from shutdown
    shdn = 1'b1; tick(3);
    shdn = 1'b0;
    for (int e = 1; e <= 2 + 5*S + 2; e++) begin
      int code;
      tick(1);
      code = (e < 2) ? 0 : (1 + (e - 2) / S);
      if (code > 5) code = 5;
      if (e < 2) chk(3, 0, 1, 0, 1, $sformatf("edge %0d", e));
      else chk((e >= 2 + 5*S) ? 4 : 3, 1, 0, 3'(code), (e >= 2 + 5*S) ? 1'b0 : 1'b1,
               $sformatf("ramp edge %0d", e));
    end

    // R5: standby mid-ramp restarts at code 1
    shdn = 1'b1; tick(3); shdn = 1'b0;
    tick(1 + 2*S + 1);
    chk(5, 1, 0, 3, 1, "mid ramp code 3");
    stby = 1'b1; tick(3);
    chk(5, 0, 0, 0, 1, "standby mid ramp");
    stby = 1'b0; tick(2);
    chk(5, 1, 0, 1, 1, "restart at code 1");
    tick(S - 1);
    chk(5, 1, 0, 1, 1, "code 1 held full step");

    // R1: synchronous reset from run
    tick(5*S);
    chk(4, 1, 0, 5, 0, "run before reset");
    rst = 1'b1; tick(1);
    chk(1, 0, 1, 0, 1, "reset from run");
    rst = 1'b0; tick(2);
    chk(1, 1, 0, 1, 1, "ramp restarts after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule